// File: doc/BRIEF.md
# Cartridge DMA Engine

The block copies bytes between a main-RAM port and a cartridge-memory port under control of a 32-bit register bus. Software loads a RAM address and a cartridge address, then starts a copy by writing one of two length registers. The length register at offset 0x08 copies from RAM to the cartridge. The length register at offset 0x0C copies from the cartridge into RAM.

The number of bytes moved is the written length plus one, shortened by the RAM start address's offset inside its 8-byte word. Before the copy, both start addresses are forced even. After the copy, both address registers point just past the moved data, and a level interrupt is raised. Software lowers the interrupt by writing the status register with bit 1 set.

Both memories use simple synchronous byte ports with one cycle of read latency. Each byte takes one read cycle followed by one write cycle. A status word reports activity and the interrupt. Eight byte-wide scratch registers hold configuration values that software can read back.

Top module: `cart_dma_engine`

## Requirements
- R1: After reset, every register reads zero, the interrupt output is low, and no memory strobe is active.
- R2: A write to the RAM-address register (offset 0x00) keeps bits [23:0] and reads back zero-extended. The cartridge-address register (offset 0x04) keeps and returns all 32 bits.
- R3: A start computes the count as raw = (value & 0x00FFFFFF) + 1, minus (masked RAM start & 7). The count is 0 when raw is not larger than that offset. The count is stored in the length register that was written and reads back from it.
- R4: The copy begins at RAM address (RAM register & 0x7FFFFE) and cartridge address (cartridge register & 0xFFFFFFFE). It moves bytes from consecutive addresses on both sides. Each port address is the low RAM_AW or CART_AW bits of the running address, so addresses wrap at the memory size.
- R5: A write to offset 0x08 copies RAM to cartridge, and a write to offset 0x0C copies cartridge to RAM. The source memory is never written.
- R6: On completion, the RAM-address register holds (masked RAM start + count) modulo 2^24, and the cartridge-address register holds masked cartridge start + count.
- R7: Each byte takes two cycles: a source read, then a destination write. With count c, the interrupt output rises 2c+1 clock edges after the edge that accepts the start. Memory strobes are active only while busy, and at most one strobe is active in any cycle.
- R8: A length-register write that arrives while a copy is busy is ignored. Neither length register, the copy, nor the memories change because of it.
- R9: Completion sets the interrupt, and it stays high until a status write (offset 0x10) with bit 1 set. If completion and clearing happen in the same cycle, completion wins.
- R10: The status word has bit 0 = copy busy, bit 1 = memory ports busy (same as bit 0), bit 2 = error (always 0), bit 3 = interrupt state. All other bits are 0.
- R11: Eight scratch registers sit at offsets 0x14 to 0x30. Each keeps the low 8 bits of a write and reads back zero-extended, without affecting the others.
- R12: Read data appears on the bus output in the cycle after the read strobe. Offsets with nonzero low two bits, and offsets above 0x30, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 6 | Register byte offset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, one cycle after the read strobe |
| irq_o | output | 1 | Level interrupt, set on copy completion |
| ram_addr_o | output | RAM_AW | RAM byte address |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the strobe |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| cart_addr_o | output | CART_AW | Cartridge byte address |
| cart_rd_o | output | 1 | Cartridge read strobe |
| cart_rdata_i | input | 8 | Cartridge read data, one cycle after the strobe |
| cart_wr_o | output | 1 | Cartridge write strobe |
| cart_wdata_o | output | 8 | Cartridge write data |

## Verification
The assertions assume that both memories return read data exactly one cycle after a read strobe. They also assume that bus strobes are sampled only on clock edges, and that reset is held for at least one edge. The stimulus respects these assumptions. The bench models both memories with registered reads of exactly one cycle. It changes bus signals only on falling edges and drives at most one strobe per access.

// File: rtl/cart_dma_pkg.sv
package cart_dma_pkg;

  localparam int WORD_W   = 32;
  localparam int RAMREG_W = 24;
  localparam int LEN_W    = 24;
  localparam int CNT_W    = LEN_W + 1;
  localparam int SLOT_W   = 4;

  localparam logic [SLOT_W-1:0] SLOT_RAM     = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_CART    = 4'd1;
  localparam logic [SLOT_W-1:0] SLOT_TO_CART = 4'd2;
  localparam logic [SLOT_W-1:0] SLOT_TO_RAM  = 4'd3;
  localparam logic [SLOT_W-1:0] SLOT_STATUS  = 4'd4;
  localparam logic [SLOT_W-1:0] SLOT_SCR0    = 4'd5;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_READ,
    MV_WRITE,
    MV_FINISH
  } mover_state_e;

  function automatic logic [RAMREG_W-1:0] ram_start_of(input logic [RAMREG_W-1:0] a);
    return a & 24'h7F_FFFE;
  endfunction

  function automatic logic [WORD_W-1:0] cart_start_of(input logic [WORD_W-1:0] a);
    return a & 32'hFFFF_FFFE;
  endfunction

  function automatic logic [CNT_W-1:0] trim_count(input logic [LEN_W-1:0] len,
                                                  input logic [2:0] off);
    logic [CNT_W-1:0] raw;
    logic [CNT_W-1:0] sub;
    raw = {1'b0, len} + 25'd1;
    sub = {22'd0, off};
    return (raw > sub) ? (raw - sub) : '0;
  endfunction

endpackage

// File: rtl/cart_dma_scratch.sv
module cart_dma_scratch #(
  parameter int NUM   = 8,
  parameter int W     = 8,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     vals_o [NUM]
);

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic [W-1:0] val_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        val_q <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        val_q <= wr_data_i;
      end
    end
    assign vals_o[g] = val_q;
  end

endmodule

// File: rtl/cart_dma_mover.sv
module cart_dma_mover
  import cart_dma_pkg::*;
#(
  parameter int RAM_AW  = 23,
  parameter int CART_AW = 26
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                to_cart_i,
  input  logic [RAMREG_W-1:0] ram_base_i,
  input  logic [WORD_W-1:0]   cart_base_i,
  input  logic [CNT_W-1:0]    count_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [RAMREG_W-1:0] ram_end_o,
  output logic [WORD_W-1:0]   cart_end_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic                ram_rd_o,
  input  logic [7:0]          ram_rdata_i,
  output logic                ram_wr_o,
  output logic [7:0]          ram_wdata_o,
  output logic [CART_AW-1:0]  cart_addr_o,
  output logic                cart_rd_o,
  input  logic [7:0]          cart_rdata_i,
  output logic                cart_wr_o,
  output logic [7:0]          cart_wdata_o
);

  mover_state_e        state_q;
  logic                to_cart_q;
  logic [RAMREG_W-1:0] ram_ptr_q;
  logic [WORD_W-1:0]   cart_ptr_q;
  logic [CNT_W-1:0]    left_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= MV_IDLE;
      to_cart_q  <= 1'b0;
      ram_ptr_q  <= '0;
      cart_ptr_q <= '0;
      left_q     <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: begin
          if (start_i) begin
            to_cart_q  <= to_cart_i;
            ram_ptr_q  <= ram_base_i;
            cart_ptr_q <= cart_base_i;
            left_q     <= count_i;
            state_q    <= (count_i == '0) ? MV_FINISH : MV_READ;
          end
        end
        MV_READ: state_q <= MV_WRITE;
        MV_WRITE: begin
          ram_ptr_q  <= ram_ptr_q + 1'b1;
          cart_ptr_q <= cart_ptr_q + 1'b1;
          left_q     <= left_q - 1'b1;
          state_q    <= (left_q == CNT_W'(1)) ? MV_FINISH : MV_READ;
        end
        MV_FINISH: state_q <= MV_IDLE;
        default:   state_q <= MV_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != MV_IDLE);
  assign done_o       = (state_q == MV_FINISH);
  assign ram_end_o    = ram_ptr_q;
  assign cart_end_o   = cart_ptr_q;

  assign ram_addr_o   = ram_ptr_q[RAM_AW-1:0];
  assign cart_addr_o  = cart_ptr_q[CART_AW-1:0];
  assign ram_rd_o     = (state_q == MV_READ)  &&  to_cart_q;
  assign cart_rd_o    = (state_q == MV_READ)  && !to_cart_q;
  assign cart_wr_o    = (state_q == MV_WRITE) &&  to_cart_q;
  assign ram_wr_o     = (state_q == MV_WRITE) && !to_cart_q;
  assign cart_wdata_o = ram_rdata_i;
  assign ram_wdata_o  = cart_rdata_i;

endmodule

// File: rtl/cart_dma_engine.sv
module cart_dma_engine
  import cart_dma_pkg::*;
#(
  parameter int RAM_AW      = 23,
  parameter int CART_AW     = 26,
  parameter int NUM_SCRATCH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [5:0]         bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o,
  output logic [RAM_AW-1:0]  ram_addr_o,
  output logic               ram_rd_o,
  input  logic [7:0]         ram_rdata_i,
  output logic               ram_wr_o,
  output logic [7:0]         ram_wdata_o,
  output logic [CART_AW-1:0] cart_addr_o,
  output logic               cart_rd_o,
  input  logic [7:0]         cart_rdata_i,
  output logic               cart_wr_o,
  output logic [7:0]         cart_wdata_o
);

  localparam int SCR_IDX_W = $clog2(NUM_SCRATCH);

  logic [RAMREG_W-1:0] ram_addr_q;
  logic [WORD_W-1:0]   cart_addr_q;
  logic [CNT_W-1:0]    len_to_cart_q;
  logic [CNT_W-1:0]    len_to_ram_q;
  logic                irq_q;
  logic [WORD_W-1:0]   rdata_q;

  // decoded bus events
  logic                aligned;
  logic [SLOT_W-1:0]   slot;
  logic [SLOT_W-1:0]   scr_rel;
  logic                scr_hit;
  logic                wr_hit;
  logic                start_req;
  logic                start_go;
  logic                irq_clear_evt;
  logic                busy;
  logic                done_evt;
  logic [RAMREG_W-1:0] ram_base;
  logic [WORD_W-1:0]   cart_base;
  logic [CNT_W-1:0]    count;
  logic [RAMREG_W-1:0] ram_end;
  logic [WORD_W-1:0]   cart_end;
  logic [7:0]          scr_vals [NUM_SCRATCH];
  logic [WORD_W-1:0]   rd_word;

  assign aligned       = (bus_addr_i[1:0] == 2'b00);
  assign slot          = bus_addr_i[5:2];
  assign scr_rel       = slot - SLOT_SCR0;
  assign scr_hit       = (slot >= SLOT_SCR0) && (scr_rel < SLOT_W'(NUM_SCRATCH));
  assign wr_hit        = bus_wr_i && aligned;
  assign start_req     = wr_hit && ((slot == SLOT_TO_CART) || (slot == SLOT_TO_RAM));
  assign start_go      = start_req && !busy;
  assign irq_clear_evt = wr_hit && (slot == SLOT_STATUS) && bus_wdata_i[1];

  assign ram_base  = ram_start_of(ram_addr_q);
  assign cart_base = cart_start_of(cart_addr_q);
  assign count     = trim_count(bus_wdata_i[LEN_W-1:0], ram_base[2:0]);

  cart_dma_mover #(
    .RAM_AW (RAM_AW),
    .CART_AW(CART_AW)
  ) u_mover (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_go),
    .to_cart_i   (slot == SLOT_TO_CART),
    .ram_base_i  (ram_base),
    .cart_base_i (cart_base),
    .count_i     (count),
    .busy_o      (busy),
    .done_o      (done_evt),
    .ram_end_o   (ram_end),
    .cart_end_o  (cart_end),
    .ram_addr_o  (ram_addr_o),
    .ram_rd_o    (ram_rd_o),
    .ram_rdata_i (ram_rdata_i),
    .ram_wr_o    (ram_wr_o),
    .ram_wdata_o (ram_wdata_o),
    .cart_addr_o (cart_addr_o),
    .cart_rd_o   (cart_rd_o),
    .cart_rdata_i(cart_rdata_i),
    .cart_wr_o   (cart_wr_o),
    .cart_wdata_o(cart_wdata_o)
  );

  cart_dma_scratch #(
    .NUM(NUM_SCRATCH),
    .W  (8)
  ) u_scratch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_hit && scr_hit),
    .wr_idx_i (scr_rel[SCR_IDX_W-1:0]),
    .wr_data_i(bus_wdata_i[7:0]),
    .vals_o   (scr_vals)
  );

  // address registers: completion overrides a same-cycle software write
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ram_addr_q  <= '0;
      cart_addr_q <= '0;
    end else if (done_evt) begin
      ram_addr_q  <= ram_end;
      cart_addr_q <= cart_end;
    end else if (wr_hit) begin
      if (slot == SLOT_RAM)  ram_addr_q  <= bus_wdata_i[RAMREG_W-1:0];
      if (slot == SLOT_CART) cart_addr_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      len_to_cart_q <= '0;
      len_to_ram_q  <= '0;
    end else if (start_go) begin
      if (slot == SLOT_TO_CART) len_to_cart_q <= count;
      else                      len_to_ram_q  <= count;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)            irq_q <= 1'b0;
    else if (done_evt)      irq_q <= 1'b1;
    else if (irq_clear_evt) irq_q <= 1'b0;
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if (scr_hit) begin
        rd_word = {24'd0, scr_vals[scr_rel[SCR_IDX_W-1:0]]};
      end else begin
        unique case (slot)
          SLOT_RAM:     rd_word = {8'd0, ram_addr_q};
          SLOT_CART:    rd_word = cart_addr_q;
          SLOT_TO_CART: rd_word = {7'd0, len_to_cart_q};
          SLOT_TO_RAM:  rd_word = {7'd0, len_to_ram_q};
          SLOT_STATUS:  rd_word = {28'd0, irq_q, 1'b0, busy, busy};
          default:      rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_word;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/cart_dma_checker.sv
module cart_dma_checker
  import cart_dma_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             done_evt,
  input logic             start_req,
  input logic             start_go,
  input logic             irq_clear_evt,
  input logic             irq_o,
  input logic             ram_rd_o,
  input logic             ram_wr_o,
  input logic             cart_rd_o,
  input logic             cart_wr_o,
  input logic [CNT_W-1:0] len_to_cart_q,
  input logic [CNT_W-1:0] len_to_ram_q
);

  AST_STROBES_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !(ram_rd_o || ram_wr_o || cart_rd_o || cart_wr_o)); // R7

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_rd_o, ram_wr_o, cart_rd_o, cart_wr_o})); // R7

  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_wr_o || cart_wr_o) |-> $past(ram_rd_o || cart_rd_o)); // R7

  AST_START_MAKES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go |=> busy); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && busy) |=> ($stable(len_to_cart_q) && $stable(len_to_ram_q))); // R8

  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt |=> irq_o); // R9

  AST_IRQ_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clear_evt && !done_evt) |=> !irq_o); // R9

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clear_evt) |=> irq_o); // R9

endmodule

bind cart_dma_engine cart_dma_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy         (busy),
  .done_evt     (done_evt),
  .start_req    (start_req),
  .start_go     (start_go),
  .irq_clear_evt(irq_clear_evt),
  .irq_o        (irq_o),
  .ram_rd_o     (ram_rd_o),
  .ram_wr_o     (ram_wr_o),
  .cart_rd_o    (cart_rd_o),
  .cart_wr_o    (cart_wr_o),
  .len_to_cart_q(len_to_cart_q),
  .len_to_ram_q (len_to_ram_q)
);

// File: tb/cart_dma_engine_test.sv
`timescale 1ns/1ps
module cart_dma_engine_test;

  localparam int AW    = 8;
  localparam int MSIZE = 1 << AW;
  localparam int MMASK = MSIZE - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;
  logic [AW-1:0] ram_addr, cart_addr;
  logic          ram_rd, ram_wr, cart_rd, cart_wr;
  logic [7:0]    ram_rdata = '0, cart_rdata = '0, ram_wdata, cart_wdata;

  logic [7:0] ram_mem [MSIZE];
  logic [7:0] cart_mem [MSIZE];
  logic [7:0] exp_ram [MSIZE];
  logic [7:0] exp_cart [MSIZE];

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  cart_dma_engine #(.RAM_AW(AW), .CART_AW(AW), .NUM_SCRATCH(8)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
    .ram_addr_o(ram_addr), .ram_rd_o(ram_rd), .ram_rdata_i(ram_rdata),
    .ram_wr_o(ram_wr), .ram_wdata_o(ram_wdata),
    .cart_addr_o(cart_addr), .cart_rd_o(cart_rd), .cart_rdata_i(cart_rdata),
    .cart_wr_o(cart_wr), .cart_wdata_o(cart_wdata)
  );

  always @(posedge clk) begin
    if (ram_wr)  ram_mem[ram_addr]   <= ram_wdata;
    if (ram_rd)  ram_rdata           <= ram_mem[ram_addr];
    if (cart_wr) cart_mem[cart_addr] <= cart_wdata;
    if (cart_rd) cart_rdata          <= cart_mem[cart_addr];
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int exp_count(input logic [31:0] lenv, input logic [31:0] ra);
    int raw;
    int off;
    raw = int'(lenv & 32'h00FF_FFFF) + 1;
    off = int'(ra & 32'h7F_FFFE) % 8;
    return (raw > off) ? raw - off : 0;
  endfunction

  task automatic compare_mems(input string req);
    int bad_r = 0;
    int bad_c = 0;
    for (int i = 0; i < MSIZE; i++) begin
      if (ram_mem[i] !== exp_ram[i])   bad_r++;
      if (cart_mem[i] !== exp_cart[i]) bad_c++;
    end
    check(req, "RAM mismatches", bad_r, 0);
    check(req, "cart mismatches", bad_c, 0);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // one full transfer with all its checks
  task automatic do_xfer(input bit to_cart, input logic [31:0] ra,
                         input logic [31:0] ca, input logic [31:0] lenv);
    logic [31:0] rs, cs, d;
    int c, n;
    bus_write(6'h10, 32'h2);
    bus_write(6'h00, ra);
    bus_write(6'h04, ca);
    rs = (ra & 32'h00FF_FFFF) & 32'h7F_FFFE;
    cs = ca & 32'hFFFF_FFFE;
    c  = exp_count(lenv, ra);
    for (int i = 0; i < c; i++) begin
      if (to_cart) exp_cart[(cs + i) & MMASK] = exp_ram[(rs + i) & MMASK];
      else         exp_ram[(rs + i) & MMASK]  = exp_cart[(cs + i) & MMASK];
    end
    bus_write(to_cart ? 6'h08 : 6'h0C, lenv);
    wait_irq(n);
    check("R7", "cycles to interrupt", n, 2 * c + 1);
    bus_read(to_cart ? 6'h08 : 6'h0C, d);
    check("R3", "stored count", d, c);
    bus_read(6'h00, d);
    check("R6", "RAM address after", d, (rs + c) & 32'h00FF_FFFF);
    bus_read(6'h04, d);
    check("R6", "cart address after", d, cs + c);
    compare_mems(to_cart ? "R4" : "R5");
    bus_read(6'h10, d);
    check("R10", "status after done", d, 32'h8);
    bus_write(6'h10, 32'h2);
    bus_read(6'h10, d);
    check("R9", "status after clear", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, l2;
    int n;
    logic [31:0] lens [8];
    lens = '{32'd0, 32'd1, 32'd2, 32'hFF00_0005, 32'd6, 32'd7, 32'd8, 32'd13};
    for (int i = 0; i < MSIZE; i++) begin
      ram_mem[i]  = 8'(i * 7 + 3);
      cart_mem[i] = 8'(i * 13 + 128);
      exp_ram[i]  = 8'(i * 7 + 3);
      exp_cart[i] = 8'(i * 13 + 128);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1", "irq after reset", irq, 0);
    check("R1", "strobes after reset", {ram_rd, ram_wr, cart_rd, cart_wr}, 0);
    for (int s = 0; s < 13; s++) begin
      bus_read(6'(s * 4), d);
      check("R1", "register after reset", d, 0);
    end

    // R2: address register widths
    bus_write(6'h00, 32'hFFFF_FFFF);
    bus_read(6'h00, d);
    check("R2", "RAM address width", d, 32'h00FF_FFFF);
    bus_write(6'h04, 32'hFFFF_FFFF);
    bus_read(6'h04, d);
    check("R2", "cart address width", d, 32'hFFFF_FFFF);

    // R11: scratch registers
    for (int i = 0; i < 8; i++) bus_write(6'(20 + 4 * i), 32'hA5A5_A500 | 32'(i * 17 + 1));
    for (int i = 0; i < 8; i++) begin
      bus_read(6'(20 + 4 * i), d);
      check("R11", "scratch readback", d, 32'(i * 17 + 1));
    end

    // R12: unaligned and unmapped offsets
    bus_write(6'h34, 32'h1234_5678);
    bus_read(6'h34, d);
    check("R12", "unmapped read", d, 0);
    bus_write(6'h15, 32'hFF);
    bus_read(6'h14, d);
    check("R12", "unaligned write ignored", d, 32'h1);
    bus_read(6'h01, d);
    check("R12", "unaligned read", d, 0);

    // R10: status while busy
    bus_write(6'h00, 32'h0000_0040);
    bus_write(6'h04, 32'h0000_0010);
    for (int i = 0; i < 9; i++) exp_cart[(16 + i) & MMASK] = exp_ram[(64 + i) & MMASK];
    bus_write(6'h08, 32'd8);
    bus_read(6'h10, d);
    check("R10", "status while busy", d, 32'h3);
    wait_irq(n);
    bus_read(6'h10, d);
    check("R9", "irq latched", d, 32'h8);
    compare_mems("R5");

    // R8: length writes while busy are ignored
    bus_write(6'h10, 32'h2);
    bus_read(6'h0C, l2);
    bus_write(6'h00, 32'h0000_0020);
    bus_write(6'h04, 32'h0000_0080);
    for (int i = 0; i < 6; i++) exp_cart[(128 + i) & MMASK] = exp_ram[(32 + i) & MMASK];
    bus_write(6'h08, 32'd5);
    bus_write(6'h0C, 32'd3);
    bus_write(6'h08, 32'd100);
    wait_irq(n);
    bus_read(6'h08, d);
    check("R8", "to-cart length kept", d, 6);
    bus_read(6'h0C, d);
    check("R8", "to-RAM length kept", d, l2);
    compare_mems("R8");
    bus_read(6'h00, d);
    check("R8", "RAM address after ignored start", d, 32'h26);

    // sweep: both directions, all word offsets, odd bits, wrap bases, lengths
    for (int dir = 0; dir < 2; dir++)
      for (int off = 0; off < 8; off++)
        for (int b = 0; b < 2; b++)
          for (int li = 0; li < 8; li++)
            do_xfer(dir == 0,
                    (b == 0 ? 32'h0000_0010 : 32'h00AB_00F0) + 32'(off),
                    (b == 0 ? 32'h0000_0031 : 32'h7FFF_FFFB) + 32'(2 * li),
                    lens[li]);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule